// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

A watchdog peripheral on a plain register bus (one write strobe, an address, write data and a combinational read port). A free-running up-counter advances on a slow tick enable. An optional prescaler can divide that tick by a power of two. If the counter runs past all ones while the watchdog is armed, the block emits a one-cycle reset pulse and restarts from the load value. Software keeps the system alive by writing the trigger register with a value different from the one it wrote last time. Each such write reloads the counter.

Arming and disarming are guarded by two-word key sequences written to a dedicated key register. Every register write is posted: the word lands in a shadow and takes effect only after a fixed number of slow ticks. Until then a per-register pending bit in the status register stays set. While the watchdog runs, posted writes to the prescaler control and load registers complete without changing anything.

Register addresses: 0 control, 1 load, 2 trigger, 3 key (reads back the run state in bit 0), 4 status, 5 counter value (read only). Any other address reads zero.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog is stopped, the counter, load, trigger and control registers read zero, the status register reads zero and `wdogRst` is low.
- R2: A write to control, load, trigger or key sets status bit 0, 1, 2 or 3 respectively in the next cycle. The write is applied, and its bit cleared, on the second slow tick that follows the write cycle. A repeated write while pending restarts that wait with the new data.
- R3: Writing 0xBBBB and then 0x4444 as two consecutive applied key-register writes arms the watchdog; the key register then reads 1.
- R4: Writing 0xAAAA and then 0x5555 as two consecutive applied key-register writes stops the watchdog; the key register then reads 0 and the counter holds its value.
- R5: A key word that does not complete a pair (a wrong second word, or an unrelated value) clears the partial sequence and leaves the run state unchanged. Writes to other registers do not break a sequence.
- R6: While running with the prescaler disabled, the counter increases by one on every slow tick. While stopped it holds.
- R7: Control bit 0 enables the prescaler and bits [4:2] hold a value p. With the prescaler enabled, the counter advances once every 2^p slow ticks.
- R8: A control or load write that is applied while the watchdog runs leaves that register unchanged.
- R9: An applied trigger write whose value differs from the trigger register reloads the counter from the load register and restarts the prescale phase. A write of the same value does not reload.
- R10: A counter step from all ones while running drives `wdogRst` high for exactly the next cycle and sets the counter to the load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slow time-base tick, one clock wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| wdogRst | output | 1 | One-cycle reset pulse on expiry |

## Verification
A wrong key-sequence state shows at the key register within one cycle of the second key write being applied. It also shows as a counter that either moves or freezes on the next tick. A faulty pending counter moves the cycle at which a status bit clears and at which a register changes, so a cycle-exact comparison flags it on the tick where it happens. A prescaler or reload error changes the counter value at the very next tick, long before the pulse on `wdogRst` would reveal it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [15:0] KEY_STOP_A  = 16'hAAAA;
  localparam logic [15:0] KEY_STOP_B  = 16'h5555;
  localparam logic [15:0] KEY_START_A = 16'hBBBB;
  localparam logic [15:0] KEY_START_B = 16'h4444;

  localparam int A_CTRL = 0;
  localparam int A_LOAD = 1;
  localparam int A_TRIG = 2;
  localparam int A_KEY  = 3;
  localparam int A_STAT = 4;
  localparam int A_CNT  = 5;

  typedef enum logic [1:0] {KS_IDLE, KS_STOP1, KS_START1} keyState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic running;
    logic preEn;
    logic reload;
  } wdStrb_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 3,
  parameter int PTV_W      = 3,
  parameter int PTV_OFF    = 2,
  parameter int PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata,
  output wdStrb_t           strb,
  output logic [PTV_W-1:0]  ptv,
  output logic [CNT_W-1:0]  loadVal,
  output logic [3:0]        pendVec
);
  localparam int NREG = 4;
  localparam int PC_W = $clog2(PEND_TICKS + 1);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'(1) | (DATA_W'((1 << PTV_W) - 1) << PTV_OFF);

  logic [NREG-1:0]   fire;
  logic [DATA_W-1:0] shadowArr [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_post
    logic [PC_W-1:0]   pcnt;
    logic [DATA_W-1:0] shadow;
    logic              hit;
    assign hit = wrEn && (addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendVec[i] <= 1'b0;
        pcnt       <= '0;
        shadow     <= '0;
      end else if (hit) begin
        pendVec[i] <= 1'b1;
        pcnt       <= '0;
        shadow     <= wdata;
      end else if (pendVec[i] && tickEn) begin
        if (pcnt == PC_W'(PEND_TICKS - 1)) pendVec[i] <= 1'b0;
        else                               pcnt <= pcnt + 1'b1;
      end
    end
    assign fire[i] = pendVec[i] && tickEn && !hit &&
                     (pcnt == PC_W'(PEND_TICKS - 1));
    assign shadowArr[i] = shadow;
  end

  logic [DATA_W-1:0] ctrlR, trigR;
  logic [CNT_W-1:0]  loadR;
  logic              running;
  keyState_t         keyState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR    <= '0;
      loadR    <= '0;
      trigR    <= '0;
      running  <= 1'b0;
      keyState <= KS_IDLE;
    end else begin
      if (fire[A_CTRL] && !running) ctrlR <= shadowArr[A_CTRL] & CTRL_MASK;
      if (fire[A_LOAD] && !running) loadR <= shadowArr[A_LOAD][CNT_W-1:0];
      if (fire[A_TRIG])             trigR <= shadowArr[A_TRIG];
      if (fire[A_KEY]) begin
        if (shadowArr[A_KEY] == DATA_W'(KEY_STOP_A)) begin
          keyState <= KS_STOP1;
        end else if (shadowArr[A_KEY] == DATA_W'(KEY_START_A)) begin
          keyState <= KS_START1;
        end else if (keyState == KS_STOP1 &&
                     shadowArr[A_KEY] == DATA_W'(KEY_STOP_B)) begin
          running  <= 1'b0;
          keyState <= KS_IDLE;
        end else if (keyState == KS_START1 &&
                     shadowArr[A_KEY] == DATA_W'(KEY_START_B)) begin
          running  <= 1'b1;
          keyState <= KS_IDLE;
        end else begin
          keyState <= KS_IDLE;
        end
      end
    end
  end

  assign strb.running = running;
  assign strb.preEn   = ctrlR[0];
  assign strb.reload  = fire[A_TRIG] && (shadowArr[A_TRIG] != trigR);
  assign ptv          = ctrlR[PTV_OFF +: PTV_W];
  assign loadVal      = loadR;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_CTRL): rdata = ctrlR;
      ADDR_W'(A_LOAD): rdata = DATA_W'(loadR);
      ADDR_W'(A_TRIG): rdata = trigR;
      ADDR_W'(A_KEY):  rdata = DATA_W'(running);
      ADDR_W'(A_STAT): rdata = DATA_W'(pendVec);
      ADDR_W'(A_CNT):  rdata = DATA_W'(count);
      default:         rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  wdStrb_t          strb,
  input  logic [PTV_W-1:0] ptv,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             wdogRst
);
  localparam int PRE_W = (1 << PTV_W) - 1;

  logic [PRE_W-1:0] preCnt, preLimit;
  logic             phaseDone;

  assign preLimit  = {PRE_W{1'b1}} >> (PRE_W - int'(ptv));
  assign phaseDone = !strb.preEn || (preCnt == preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      preCnt  <= '0;
      wdogRst <= 1'b0;
    end else begin
      wdogRst <= 1'b0;
      if (strb.reload) begin
        count  <= loadVal;
        preCnt <= '0;
      end else if (strb.running && tickEn) begin
        if (phaseDone) begin
          preCnt <= '0;
          if (count == '1) begin
            count   <= loadVal;
            wdogRst <= 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 3,
  parameter int PTV_W      = 3,
  parameter int PTV_OFF    = 2,
  parameter int PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdogRst
);
  wdStrb_t          strb;
  logic [PTV_W-1:0] ptv;
  logic [CNT_W-1:0] loadVal, count;
  logic [3:0]       pendVec;

  wdog_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .PTV_W(PTV_W), .PTV_OFF(PTV_OFF), .PEND_TICKS(PEND_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .count(count), .rdata(rdata), .strb(strb), .ptv(ptv),
    .loadVal(loadVal), .pendVec(pendVec)
  );

  wdog_dp #(.CNT_W(CNT_W), .PTV_W(PTV_W)) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .ptv(ptv),
    .loadVal(loadVal), .count(count), .wdogRst(wdogRst)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              running,
  input logic              preEn,
  input logic              reload,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  loadVal,
  input logic [3:0]        pendVec,
  input logic              wdogRst
);
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |=> !wdogRst);

  p_pulse_from_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogRst) |-> ($past(count) == '1));

  p_load_pend_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(1)) |=> pendVec[1]);

  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !reload) |=> $stable(count));

  p_tick_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && !preEn && !reload && count != '1)
      |=> ((count - $past(count)) == CNT_W'(1)));

  p_load_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(loadVal));
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
  .running(strb.running), .preEn(strb.preEn), .reload(strb.reload),
  .count(count), .loadVal(loadVal), .pendVec(pendVec), .wdogRst(wdogRst)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wdogRst;

  int checks = 0, failures = 0;
  int tickEvery = 1, phase = 0, rot = 0, pulses = 0;
  bit started = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdogRst(wdogRst)
  );

  // ---------------- behavioural reference model ----------------
  int mCnt, mLoad, mTrig, mPre, mPreEn, mPtv, mRun, mKs, mRst;
  int mPend[4], mPc[4], mSh[4];

  function automatic int modelRead(int a);
    case (a)
      0: return (mPtv << 2) | mPreEn;
      1: return mLoad;
      2: return mTrig;
      3: return mRun;
      4: return mPend[0] | (mPend[1] << 1) | (mPend[2] << 2) | (mPend[3] << 3);
      5: return mCnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mLoad = 0; mTrig = 0; mPre = 0; mPreEn = 0; mPtv = 0;
      mRun = 0; mKs = 0; mRst = 0;
      for (int i = 0; i < 4; i++) begin mPend[i] = 0; mPc[i] = 0; mSh[i] = 0; end
    end else begin
      int oldRun, oldLoad, doReload, newRst;
      oldRun = mRun; oldLoad = mLoad; doReload = 0; newRst = 0;
      for (int i = 0; i < 4; i++) begin
        if (wrEn && addr == i) begin
          mPend[i] = 1; mPc[i] = 0; mSh[i] = wdata;
        end else if (mPend[i] == 1 && tickEn) begin
          if (mPc[i] == 1) begin
            mPend[i] = 0;
            case (i)
              0: if (oldRun == 0) begin mPreEn = mSh[0] & 1; mPtv = (mSh[0] >> 2) & 7; end
              1: if (oldRun == 0) mLoad = mSh[1];
              2: begin if (mSh[2] != mTrig) doReload = 1; mTrig = mSh[2]; end
              default: begin
                if (mSh[3] == 'hAAAA) mKs = 1;
                else if (mSh[3] == 'hBBBB) mKs = 2;
                else if (mKs == 1 && mSh[3] == 'h5555) begin mRun = 0; mKs = 0; end
                else if (mKs == 2 && mSh[3] == 'h4444) begin mRun = 1; mKs = 0; end
                else mKs = 0;
              end
            endcase
          end else mPc[i]++;
        end
      end
      if (doReload) begin
        mCnt = oldLoad; mPre = 0;
      end else if (oldRun == 1 && tickEn) begin
        if (mPreEn == 0 || mPre == (1 << mPtv) - 1) begin
          mPre = 0;
          if (mCnt == 'hFFFF) begin mCnt = oldLoad; newRst = 1; end
          else mCnt++;
        end else mPre++;
      end
      mRst = newRst;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagFor(int a);
    case (a)
      0: return "R7 ctrl readback";
      1: return "R8 load readback";
      2: return "R9 trigger readback";
      3: return "R3 run state";
      4: return "R2 pending status";
      5: return "R6 counter value";
      default: return "R1 unmapped address";
    endcase
  endfunction

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && started && !done) begin
      chk("R10 wdogRst", int'(wdogRst), mRst);
      chk(tagFor(int'(addr)), int'(rdata), modelRead(int'(addr)));
      if (wdogRst) pulses++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(bit w, int a, int d);
    @(negedge clk);
    tickEn = (phase % tickEvery) == 0;
    phase++;
    wrEn = w; addr = 3'(a); wdata = 16'(d);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      drive(0, rot, 0);
      rot = (rot + 1) % 7;
    end
  endtask

  task automatic wr(int a, int d);
    drive(1, a, d);
    step(3 * tickEvery + 2);
  endtask

  task automatic rd(int a, output int v);
    drive(0, a, 0);
    #(CLK_PERIOD/4);
    v = int'(rdata);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, a0, b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    started = 1;
    // R1 reset state
    rd(5, v); chk("R1 counter after reset", v, 0);
    rd(1, v); chk("R1 load after reset", v, 0);
    rd(4, v); chk("R1 status after reset", v, 0);
    rd(3, v); chk("R1 stopped after reset", v, 0);
    chk("R1 wdogRst after reset", int'(wdogRst), 0);

    // R2 posted write
    drive(1, 1, 'hFFF0);
    rd(4, v); chk("R2 load pending bit", v, 2);
    step(4);
    rd(4, v); chk("R2 pending cleared", v, 0);
    rd(1, v); chk("R2 load applied", v, 'hFFF0);
    wr(2, 'h0001);

    // R3 start
    wr(3, 'hBBBB); wr(3, 'h4444);
    rd(3, v); chk("R3 started", v, 1);
    rd(5, a0); step(3); rd(5, b0);
    chk("R6 counter advancing", int'(b0 != a0), 1);

    // R5 broken stop sequence
    wr(3, 'hAAAA); wr(3, 'h1234); wr(3, 'h5555);
    rd(3, v); chk("R5 still running", v, 1);

    // R8 config frozen while running
    wr(1, 'h0100); wr(0, 'h0009);
    rd(1, v); chk("R8 load unchanged", v, 'hFFF0);
    rd(0, v); chk("R8 ctrl unchanged", v, 0);

    // R9 trigger toggling
    wr(2, 'h1234);
    wr(2, 'h1234);
    rd(2, v); chk("R9 trigger value", v, 'h1234);

    // R10 expiry
    step(40);
    chk("R10 pulse seen", int'(pulses > 0), 1);

    // R4 stop
    wr(3, 'hAAAA); wr(3, 'h5555);
    rd(3, v); chk("R4 stopped", v, 0);
    rd(5, a0); step(6); rd(5, b0);
    chk("R4 counter holds", b0, a0);

    // R7 prescaler with slower tick
    tickEvery = 3;
    wr(0, 'h0009); wr(1, 'hFFFA); wr(2, 'hEDCB);
    rd(0, v); chk("R7 ctrl applied", v, 9);
    wr(3, 'hBBBB); wr(3, 'h1111); wr(3, 'h4444);
    rd(3, v); chk("R5 bad start ignored", v, 0);
    wr(3, 'hBBBB); wr(1, 'h0000); wr(3, 'h4444);
    rd(3, v); chk("R5 other writes keep sequence", v, 1);
    pulses = 0;
    step(400);
    chk("R10 prescaled expiry", int'(pulses > 0), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule